// File: doc/BRIEF.md
# Folded Single-Bit RAM

This block stores a memory that is one bit wide and `ROWS x COLS` bits deep. The bits sit in a short, wide array of `ROWS` rows, each `COLS` bits wide, and not in one tall column of single bits. The incoming binary address is split into two fields. The upper field goes to a binary-to-one-hot decoder, which raises exactly one row-select line. The lower field steers a column multiplexer, which picks one bit out of the selected row.

A write is synchronous. On a rising clock edge with the write enable high, the input bit is stored at the addressed position. A read is combinational: the output follows the address without waiting for a clock edge. An active-low reset clears every cell to zero. Both `ROWS` and `COLS` must be powers of two.

The block has no state machine. The storage rows are the only state, and each row register is either holding its value or loading one bit.

Top module: `folded_bit_ram`

## Requirements
- R1: While reset is low and after it is released, every cell reads 0 until it is written.
- R2: On a rising edge with `wr_en` at 1, the value of `wr_bit` is stored at address `addr`. Bits `addr[AW-1:CB]` select the row and bits `addr[CB-1:0]` select the column.
- R3: On a rising edge with `wr_en` at 0, no stored bit changes.
- R4: A write leaves the other `COLS-1` bits of the addressed row unchanged.
- R5: A write leaves every bit of every other row unchanged.
- R6: `rd_bit` is a combinational function of `addr`. It shows the stored bit at `addr` with no clock edge in between.
- R7: After a write, a read of the same address returns the new value from the edge of that write onward. A change of `wr_bit` after the edge has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all cells |
| wr_en | input | 1 | Write enable |
| addr | input | AW = log2(ROWS)+log2(COLS) | Bit address: row in the upper field, column in the lower field |
| wr_bit | input | 1 | Data bit to store |
| rd_bit | output | 1 | Data bit at `addr` |

## Verification
A write becomes visible at the first rising edge where `wr_en` is high. It is due one edge after the inputs are set up. The bench drives inputs at the falling edge and samples `rd_bit` one time unit after the next rising edge. Reads take zero cycles, so the bench also changes `addr` between edges and samples a time unit later, with no edge in between. The checks for R3, R4 and R5 read back the neighbouring addresses after the edge in question, before any further write.

// File: rtl/folded_bit_ram_pkg.sv
package folded_bit_ram_pkg;
    localparam int FR_DEF_ROWS = 16;
    localparam int FR_DEF_COLS = 8;
endpackage

// File: rtl/fr_row_decoder.sv
module fr_row_decoder #(
    parameter int ROWS = 16,
    localparam int RB = $clog2(ROWS)
) (
    input  logic [RB-1:0]   row_idx,
    output logic [ROWS-1:0] row_sel
);
    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign row_sel[r] = (row_idx == RB'(r));
    end

    always_comb begin
        if (!$isunknown(row_idx))
            AST_ROW_ONE_HOT: assert ($countones(row_sel) == 1); // R2
    end
endmodule

// File: rtl/fr_cell_array.sv
module fr_cell_array #(
    parameter int ROWS = 16,
    parameter int COLS = 8,
    localparam int CB = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [ROWS-1:0] row_sel,
    input  logic [CB-1:0]   col_idx,
    input  logic            din,
    output logic [COLS-1:0] row_q
);
    logic [COLS-1:0] cells [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[r] <= '0;
            else if (we && row_sel[r])
                cells[r][col_idx] <= din;
        end

        AST_ROW_LOADS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (we && row_sel[r]) |=> (cells[r][$past(col_idx)] == $past(din))); // R2

        AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && row_sel[r]) |=> $stable(cells[r])); // R5
    end

    always_comb begin
        row_q = '0;
        for (int r = 0; r < ROWS; r++)
            row_q = row_q | (cells[r] & {COLS{row_sel[r]}});
    end
endmodule

// File: rtl/fr_col_mux.sv
module fr_col_mux #(
    parameter int COLS = 8,
    localparam int CB = $clog2(COLS)
) (
    input  logic [COLS-1:0] row_q,
    input  logic [CB-1:0]   col_idx,
    output logic            bit_q
);
    assign bit_q = row_q[col_idx];
endmodule

// File: rtl/folded_bit_ram.sv
module folded_bit_ram
    import folded_bit_ram_pkg::*;
#(
    parameter int ROWS = FR_DEF_ROWS,
    parameter int COLS = FR_DEF_COLS,
    localparam int RB = $clog2(ROWS),
    localparam int CB = $clog2(COLS),
    localparam int AW = RB + CB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          wr_bit,
    output logic          rd_bit
);
    logic [RB-1:0]   row_idx;
    logic [CB-1:0]   col_idx;
    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] row_q;

    assign row_idx = addr[AW-1:CB];
    assign col_idx = addr[CB-1:0];

    fr_row_decoder #(.ROWS(ROWS)) u_dec (
        .row_idx (row_idx),
        .row_sel (row_sel)
    );

    fr_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .row_sel (row_sel),
        .col_idx (col_idx),
        .din     (wr_bit),
        .row_q   (row_q)
    );

    fr_col_mux #(.COLS(COLS)) u_mux (
        .row_q   (row_q),
        .col_idx (col_idx),
        .bit_q   (rd_bit)
    );

    AST_READ_NEW_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$isunknown(addr)) ##1 (addr == $past(addr)) |-> (rd_bit == $past(wr_bit))); // R7

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$isunknown(addr)) ##1 (addr == $past(addr)) |-> $stable(rd_bit)); // R3
endmodule

// File: tb/folded_bit_ram_test.sv
module folded_bit_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 16;
    localparam int COLS = 8;
    localparam int CB = $clog2(COLS);
    localparam int AW = $clog2(ROWS) + CB;
    localparam int N = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic wr_bit = 1'b0;
    logic rd_bit;

    int checks = 0;
    int failures = 0;
    bit model [N];

    folded_bit_ram #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wr_bit(wr_bit), .rd_bit(rd_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int a, input logic exp);
        checks++;
        if (rd_bit !== exp) begin
            failures++;
            $display("FAIL %s addr=%0d actual=%b expected=%b", req, a, rd_bit, exp);
        end
    endtask

    // Compare every address against the model, with no clock edge in between.
    task automatic sweep(input string req);
        for (int a = 0; a < N; a++) begin
            addr = AW'(a);
            #1;
            check(req, a, model[a]);
        end
    endtask

    task automatic write(input int a, input bit v, input bit en);
        @(negedge clk);
        wr_en = en; addr = AW'(a); wr_bit = v;
        @(posedge clk);
        #1;
        if (en) model[a] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state;
        for (int a = 0; a < N; a++) model[a] = 1'b0;
        sweep("R1");
    endtask

    task automatic t_write_pattern;
        for (int a = 0; a < N; a++) write(a, bit'((a ^ (a >> CB)) & 1), 1'b1);
        sweep("R2");
        for (int a = 0; a < N; a += 5) write(a, ~model[a], 1'b1);
        sweep("R2");
    endtask

    task automatic t_write_disabled;
        write(9, ~model[9], 1'b0);
        addr = AW'(9); #1; check("R3", 9, model[9]);
        sweep("R3");
    endtask

    task automatic t_row_neighbours;
        int base = 3 * COLS;
        for (int c = 0; c < COLS; c++) write(base + c, 1'b1, 1'b1);
        write(base + 2, 1'b0, 1'b1);
        for (int c = 0; c < COLS; c++) begin
            addr = AW'(base + c); #1; check("R4", base + c, (c == 2) ? 1'b0 : 1'b1);
        end
        for (int a = 0; a < N; a++) if (a / COLS != 3) begin
            addr = AW'(a); #1; check("R5", a, model[a]);
        end
    endtask

    task automatic t_comb_read;
        write(0, 1'b1, 1'b1);
        write(N - 1, 1'b0, 1'b1);
        @(negedge clk);
        #1;
        addr = AW'(0); #1; check("R6", 0, 1'b1);
        addr = AW'(N - 1); #1; check("R6", N - 1, 1'b0);
        addr = AW'(0); #1; check("R6", 0, 1'b1);
    endtask

    task automatic t_read_after_write;
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(77); wr_bit = ~model[77];
        @(posedge clk);
        #1;
        model[77] = ~model[77];
        check("R7", 77, model[77]);
        wr_en = 1'b0;
        wr_bit = ~wr_bit;
        #1;
        check("R7", 77, model[77]);
        @(posedge clk);
        #1;
        check("R7", 77, model[77]);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) model[a] = 1'b0;
        #(CLK_PERIOD * 2 + 1);
        addr = AW'(5); #1; check("R1", 5, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write_pattern();
        t_write_disabled();
        t_row_neighbours();
        t_comb_read();
        t_read_after_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule